// File: doc/BRIEF.md
# Banked GPIO change-interrupt controller

This block watches a wide set of general-purpose pins grouped into banks of eight. Each bank has an input register that holds the last captured pin levels. The block drives one active-low interrupt whenever a pin meets all three of these conditions:

- it is configured as an input;
- it is not masked;
- its synchronised level differs from the bit held in its bank's input register.

The interrupt output is a pull-down enable: low means the line is asserted. The open-drain pad itself is not part of this block.

Software services the interrupt through a register interface. For each bank there is a one-cycle read strobe. A read loads the current synchronised pin levels into that bank's input register. This removes the pending changes of that bank only. When changes have occurred in several banks, every one of those banks must be read before the line is released. A pin that returns to its captured level also withdraws its own request, with no read needed. A pin switched from output to input is compared against its stale register bit, so it can raise the interrupt on purpose.

Top module: `gpio_chg_irq`

## Requirements
- R1: During reset and after reset is released, `irq_no` is 1. Within three clock cycles after release, every bank of `in_reg_o` equals the pin levels that were held steady during reset.
- R2: A pin (bit b*8+k is pin k of bank b) requests the interrupt only if `dir_in_i` is 1 (input), `mask_i` is 0 (unmasked) and its level differs from the same bit of `in_reg_o`. A masked pin or an output pin with a different level leaves `irq_no` at 1.
- R3: If every differing pin returns to its captured level, `irq_no` returns to 1 without any read.
- R4: A one-cycle pulse on `rd_stb_i[b]` loads bank b of `in_reg_o` with the synchronised pin levels, masked bits included, and clears that bank's requests. The other banks and their requests are unchanged.
- R5: When pins in several banks differ, `irq_no` stays 0 until every one of those banks has been read.
- R6: Changing a pin from output to input raises the interrupt if its level differs from its stored input register bit.
- R7: A pin change that reaches the compare stage on the same clock edge as a read of its bank is kept pending. `irq_no` goes to 0 and the register keeps the pre-change value.
- R8: Pins pass through a two-flop synchroniser. `irq_no` falls on the second rising clock edge after a pin change, not on the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pin_i | input | NUM_BANKS*8 | Raw pin levels, bank b in bits b*8+7..b*8 |
| dir_in_i | input | NUM_BANKS*8 | 1 = pin is an input |
| mask_i | input | NUM_BANKS*8 | 1 = pin may not raise the interrupt |
| rd_stb_i | input | NUM_BANKS | One-cycle read strobe per bank |
| irq_no | output | 1 | Interrupt pull-down enable, 0 = asserted |
| in_reg_o | output | NUM_BANKS*8 | Captured input register contents |

## Verification
The bench reads an unrelated bank while another bank still has a change pending. A design that cleared every bank on any read would release the line there. It also reads only one of two changed banks and expects the line to stay low. A design that kept a single global flag would fail that check.

The bench flips a masked pin, flips an output pin, and then switches that output pin back to input. A design that filtered the direction switch would miss the change. Finally, it lines up a read with a change arriving at the compare stage. A design that let the read swallow the change would leave the line high.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
    localparam int unsigned BANK_W    = 8;
    localparam int unsigned PRIME_CYC = 2;

    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        bank_t in_reg;
        bank_t pend;
    } bank_state_t;
endpackage

// File: rtl/gpio_chg_sync.sv
module gpio_chg_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] meta_o,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stab;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign meta_o = st_q.meta;
    assign sync_o = st_q.stab;
endmodule

// File: rtl/gpio_chg_bank.sv
module gpio_chg_bank
    import gpio_chg_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  primed_i,
    input  bank_t sync_cur_i,
    input  bank_t sync_nxt_i,
    input  bank_t dir_in_i,
    input  bank_t mask_i,
    input  logic  rd_i,
    output bank_t in_reg_o,
    output bank_t pend_o
);
    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!primed_i) begin
            st_d.in_reg = sync_nxt_i;
        end else if (rd_i) begin
            st_d.in_reg = sync_cur_i;
        end
        if (primed_i) begin
            st_d.pend = (sync_nxt_i ^ st_d.in_reg) & dir_in_i & ~mask_i;
        end else begin
            st_d.pend = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign in_reg_o = st_q.in_reg;
    assign pend_o   = st_q.pend;
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
    import gpio_chg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_i,
    input  logic [NUM_BANKS*BANK_W-1:0] dir_in_i,
    input  logic [NUM_BANKS*BANK_W-1:0] mask_i,
    input  logic [NUM_BANKS-1:0]        rd_stb_i,
    output logic                        irq_no,
    output logic [NUM_BANKS*BANK_W-1:0] in_reg_o
);
    localparam int unsigned PIN_W = NUM_BANKS * BANK_W;
    localparam int unsigned CNT_W = $clog2(PRIME_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] prime;
    } top_state_t;

    top_state_t st_d, st_q;
    logic              primed;
    logic [PIN_W-1:0]  sync_q;
    logic [PIN_W-1:0]  sync_nxt;
    logic [PIN_W-1:0]  pend;

    assign primed = (st_q.prime == CNT_W'(PRIME_CYC));

    always_comb begin
        st_d = st_q;
        if (!primed) st_d.prime = st_q.prime + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    gpio_chg_sync #(.WIDTH(PIN_W)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_i),
        .meta_o  (sync_nxt),
        .sync_o  (sync_q)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_chg_bank u_bank (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .primed_i   (primed),
            .sync_cur_i (sync_q[b*BANK_W +: BANK_W]),
            .sync_nxt_i (sync_nxt[b*BANK_W +: BANK_W]),
            .dir_in_i   (dir_in_i[b*BANK_W +: BANK_W]),
            .mask_i     (mask_i[b*BANK_W +: BANK_W]),
            .rd_i       (rd_stb_i[b]),
            .in_reg_o   (in_reg_o[b*BANK_W +: BANK_W]),
            .pend_o     (pend[b*BANK_W +: BANK_W])
        );
    end

    assign irq_no = ~|pend;
endmodule

// File: rtl/gpio_chg_irq_chk.sv
module gpio_chg_irq_chk
    import gpio_chg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic [NUM_BANKS*BANK_W-1:0] dir_in_i,
    input logic [NUM_BANKS*BANK_W-1:0] mask_i,
    input logic [NUM_BANKS-1:0]        rd_stb_i,
    input logic                        irq_no,
    input logic [NUM_BANKS*BANK_W-1:0] in_reg_o,
    input logic [NUM_BANKS*BANK_W-1:0] sync_q,
    input logic                        primed
);
    p_quiet_priming_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !primed |-> irq_no);

    p_all_masked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed && (&mask_i)) |=> irq_no);

    p_no_inputs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed && (dir_in_i == '0)) |=> irq_no);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        p_reg_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (primed && !rd_stb_i[b]) |=> $stable(in_reg_o[b*BANK_W +: BANK_W]));

        p_read_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (primed && rd_stb_i[b]) |=>
                (in_reg_o[b*BANK_W +: BANK_W] == $past(sync_q[b*BANK_W +: BANK_W])));
    end
endmodule

bind gpio_chg_irq gpio_chg_irq_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dir_in_i (dir_in_i),
    .mask_i   (mask_i),
    .rd_stb_i (rd_stb_i),
    .irq_no   (irq_no),
    .in_reg_o (in_reg_o),
    .sync_q   (sync_q),
    .primed   (primed)
);

// File: tb/sim_gpio_chg_irq.sv
module sim_gpio_chg_irq;
    localparam int NB = 4;
    localparam int W  = NB * 8;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic [W-1:0]  pin = '0;
    logic [W-1:0]  dir = '1;
    logic [W-1:0]  mask = '0;
    logic [NB-1:0] rd = '0;
    logic          irq_no;
    logic [W-1:0]  in_reg;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    gpio_chg_irq #(.NUM_BANKS(NB)) u0 (
        .clk_i    (clk),
        .rst_ni   (rst_ni),
        .pin_i    (pin),
        .dir_in_i (dir),
        .mask_i   (mask),
        .rd_stb_i (rd),
        .irq_no   (irq_no),
        .in_reg_o (in_reg)
    );

    // pin, dir, mask, rd, expected irq_no, expected in_reg
    localparam logic [132:0] VEC [12] = '{
        {32'h00000000, 32'hFFFFFFFF, 32'h00000000, 4'b0000, 1'b1, 32'h00000000}, // R2 idle
        {32'h00000001, 32'hFFFFFFFF, 32'h00000000, 4'b0000, 1'b0, 32'h00000000}, // R2 change
        {32'h00000000, 32'hFFFFFFFF, 32'h00000000, 4'b0000, 1'b1, 32'h00000000}, // R3 return
        {32'h00000100, 32'hFFFFFFFF, 32'h00000000, 4'b0000, 1'b0, 32'h00000000}, // R2 bank1
        {32'h00000100, 32'hFFFFFFFF, 32'h00000000, 4'b0001, 1'b0, 32'h00000000}, // R4 other bank
        {32'h00000100, 32'hFFFFFFFF, 32'h00000000, 4'b0010, 1'b1, 32'h00000100}, // R4 own bank
        {32'h01000110, 32'hFFFFFFFF, 32'h00000000, 4'b0001, 1'b0, 32'h00000110}, // R5 one of two
        {32'h01000110, 32'hFFFFFFFF, 32'h00000000, 4'b1000, 1'b1, 32'h01000110}, // R5 all read
        {32'h01000111, 32'hFFFFFFFF, 32'h00000001, 4'b0000, 1'b1, 32'h01000110}, // R2 masked
        {32'h01000113, 32'hFFFFFFFD, 32'h00000001, 4'b0000, 1'b1, 32'h01000110}, // R2 output
        {32'h01000113, 32'hFFFFFFFF, 32'h00000001, 4'b0000, 1'b0, 32'h01000110}, // R6 to input
        {32'h01000113, 32'hFFFFFFFF, 32'h00000001, 4'b0001, 1'b1, 32'h01000113}  // R4 masked loads
    };

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic chk_irq(input logic exp, input string req);
        total++;
        if (irq_no !== exp) begin
            bad++;
            $display("FAIL %s irq_no actual=%b expected=%b", req, irq_no, exp);
        end
    endtask

    task automatic chk_reg(input logic [W-1:0] exp, input string req);
        total++;
        if (in_reg !== exp) begin
            bad++;
            $display("FAIL %s in_reg actual=%h expected=%h", req, in_reg, exp);
        end
    endtask

    task automatic do_reset(input logic [W-1:0] p);
        @(negedge clk);
        rst_ni = 1'b0;
        pin = p; dir = '1; mask = '0; rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;
    endtask

    task automatic pulse_rd(input logic [NB-1:0] r);
        @(negedge clk);
        rd = r;
        @(posedge clk);
        @(negedge clk);
        rd = '0;
    endtask

    initial begin
        // R1: reset with nonzero pins
        do_reset(32'h00A50000);
        chk_irq(1'b1, "R1 reset");
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_irq(1'b1, "R1 after release");
        chk_reg(32'h00A50000, "R1 capture");

        do_reset(32'h00000000);
        repeat (3) @(posedge clk);

        for (int i = 0; i < 12; i++) begin
            logic [132:0] v;
            v = VEC[i];
            @(negedge clk);
            pin  = v[132:101];
            dir  = v[100:69];
            mask = v[68:37];
            repeat (3) @(posedge clk);
            if (v[36:33] != '0) pulse_rd(v[36:33]);
            else @(negedge clk);
            chk_irq(v[32], $sformatf("R2-table vec%0d", i));
            chk_reg(v[31:0], $sformatf("R4-table vec%0d", i));
        end

        // R8: latency of two edges
        @(negedge clk);
        pin = 32'h01000013;
        @(posedge clk);
        @(negedge clk);
        chk_irq(1'b1, "R8 one edge");
        @(posedge clk);
        @(negedge clk);
        chk_irq(1'b0, "R8 two edges");
        pulse_rd(4'b0010);
        chk_irq(1'b1, "R4 clean bank1");
        chk_reg(32'h01000013, "R4 clean bank1");

        // R7: read lands on the edge where the change reaches compare
        @(negedge clk);
        pin = 32'h01000113;
        @(posedge clk);
        pulse_rd(4'b0010);
        chk_irq(1'b0, "R7 pending kept");
        chk_reg(32'h01000013, "R7 old value kept");
        pulse_rd(4'b0010);
        chk_irq(1'b1, "R7 second read");
        chk_reg(32'h01000113, "R7 second read");

        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end
endmodule